// File: doc/BRIEF.md
# Infrared Carrier and Envelope Timer Pair

This block pairs two down-counters to build an infrared transmit waveform. The narrow counter (8 bits) produces the carrier. The wide counter (16 bits) produces the envelope that switches bursts of carrier on and off. Each counter runs in phases. It loads one of two hold values, counts the hold value down to zero, then flips its output and loads the other hold value. A counter stops after one high/low period in single-pass mode, or keeps running in modulo mode. A submode of the envelope picks one of three behaviours: the normal gated output, a ping-pong chain in which each single-pass counter starts the other when it finishes, or an envelope pinned to a fixed level.

Software drives the block through a byte-wide register port with eight addresses, and reads it back through the same port. An optional sync setting holds the carrier at its start point whenever the envelope is low. Every burst therefore opens with a whole carrier pulse.

Top module: `ir_timer_pair`

## Requirements
- R1: After reset the carrier pin is 0, the envelope pin is 1, the modulated pin and both interrupt pins are 0, and both control registers read 0.
- R2: A counter is started by a write of 1 to bit 7 of its control register (address 6 for the carrier, 7 for the envelope). Its output then shows the initial level from bit 0. While the output is 1, each phase lasts low-hold+1 cycles; while it is 0, each phase lasts high-hold+1 cycles. The carrier holds sit at address 0 (high) and 1 (low). The envelope holds sit at 2/3 (high, upper/lower byte) and 4/5 (low, upper/lower byte).
- R3: With bit 6 clear (modulo), the counter alternates phases without stopping, and at the end of each full period it sets the status bit (bit 5).
- R4: With bit 6 set (single-pass), the counter stops after one high phase and one low phase. At that point bit 7 reads 0 and status bit 5 reads 1.
- R5: An interrupt pin is high exactly when its counter's status bit and mask bit (bit 1) are both 1. Writing 1 to bit 5 clears the status bit. Writing 0 to bit 5 leaves it unchanged.
- R6: While the envelope counter is stopped, the envelope pin shows the inverse of the envelope's initial level.
- R7: Envelope submode bits [3:2] = 10 force the envelope pin to 0, and 11 force it to 1, whether or not the counter runs.
- R8: In submode 00 the modulated pin is the AND of the carrier and envelope pins. The carrier pin is 0 while the carrier is stopped.
- R9: In submode 01, when both counters are single-pass, the end of one counter's run enables the other, so the two alternate.
- R10: In submode 01 the modulated pin is the OR of the carrier and envelope pins.
- R11: With envelope bit 4 (sync) set in submode 00, the carrier restarts from its initial level on every cycle in which the envelope pin is low. Each envelope high interval therefore begins with a whole carrier phase.
- R12: A hold register may be rewritten while its counter runs. The phase in progress keeps its length, and the new value applies from the next load.
- R13: Writing 0 to bit 7 stops a running counter; the carrier pin drops to 0 by the second clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| carrier_o | output | 1 | Carrier counter output |
| envelope_o | output | 1 | Envelope counter output |
| mod_o | output | 1 | Combined carrier/envelope output |
| irq_car_o | output | 1 | Carrier time-out interrupt |
| irq_env_o | output | 1 | Envelope time-out interrupt |

## Verification
The bench checks phase lengths for both initial levels. A design that uses the wrong hold value for a level produces pulses of swapped width, and a counter that is off by one in its reload makes every phase one cycle short. A 16-bit envelope hold with non-zero bytes in both halves catches a design that assembles the wrong bytes. A hold value rewritten in mid-phase must not shorten the phase in progress, which catches an early reload. The ping-pong run is checked cycle by cycle through two hand-offs, including the idle gap at each one, so a chain that fails to re-enable its partner or that gates with AND instead of OR is exposed. The sync run checks that every envelope burst starts with a carrier high pulse, which a free-running carrier would miss.

// File: rtl/irtp_pkg.sv
package irtp_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_CAR_HI   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CAR_LO   = 3'd1;
  localparam logic [ADDR_W-1:0] A_ENV_HI_H = 3'd2;
  localparam logic [ADDR_W-1:0] A_ENV_HI_L = 3'd3;
  localparam logic [ADDR_W-1:0] A_ENV_LO_H = 3'd4;
  localparam logic [ADDR_W-1:0] A_ENV_LO_L = 3'd5;
  localparam logic [ADDR_W-1:0] A_CAR_CTL  = 3'd6;
  localparam logic [ADDR_W-1:0] A_ENV_CTL  = 3'd7;

  // control bit positions
  localparam int B_EN     = 7;
  localparam int B_SINGLE = 6;
  localparam int B_STS    = 5;
  localparam int B_SYNC   = 4;
  localparam int B_MASK   = 1;
  localparam int B_INIT   = 0;

  typedef enum logic [1:0] {
    SUB_NORMAL   = 2'b00,
    SUB_PINGPONG = 2'b01,
    SUB_FORCE0   = 2'b10,
    SUB_FORCE1   = 2'b11
  } sub_e;
endpackage

// File: rtl/irtp_counter.sv
module irtp_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         single_i,
  input  logic         init_i,
  input  logic         restart_i,
  input  logic [W-1:0] hold_hi_i,
  input  logic [W-1:0] hold_lo_i,
  output logic         run_o,
  output logic         level_o,
  output logic         period_o,
  output logic         done_o
);
  logic [W-1:0] cnt_q;
  logic         level_q, phase_q, run_q;
  logic         load, tc;

  assign load     = !run_q || restart_i;
  assign tc       = run_q && !restart_i && (cnt_q == '0);
  assign period_o = tc && phase_q && en_i;
  assign done_o   = period_o && single_i;
  assign run_o    = run_q;
  assign level_o  = level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      level_q <= 1'b0;
      phase_q <= 1'b0;
      run_q   <= 1'b0;
    end else if (!en_i) begin
      run_q <= 1'b0;
    end else if (load) begin
      run_q   <= 1'b1;
      level_q <= init_i;
      phase_q <= 1'b0;
      cnt_q   <= init_i ? hold_lo_i : hold_hi_i;
    end else if (tc) begin
      if (done_o) run_q <= 1'b0;
      level_q <= ~level_q;
      phase_q <= ~phase_q;
      // next level is ~level_q: level 1 runs on the low hold
      cnt_q   <= level_q ? hold_hi_i : hold_lo_i;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/irtp_regs.sv
module irtp_regs import irtp_pkg::*; #(
  parameter int CAR_W  = 8,
  parameter int ENV_W  = 16,
  parameter int DW     = DATA_W,
  parameter int AW     = ADDR_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic             car_period_i,
  input  logic             car_done_i,
  input  logic             env_period_i,
  input  logic             env_done_i,
  output logic [CAR_W-1:0] car_hi_o,
  output logic [CAR_W-1:0] car_lo_o,
  output logic [ENV_W-1:0] env_hi_o,
  output logic [ENV_W-1:0] env_lo_o,
  output logic             car_en_o,
  output logic             car_single_o,
  output logic             car_sts_o,
  output logic             car_mask_o,
  output logic             car_init_o,
  output logic             env_en_o,
  output logic             env_single_o,
  output logic             env_sts_o,
  output logic             env_sync_o,
  output sub_e             env_sub_o,
  output logic             env_mask_o,
  output logic             env_init_o,
  output logic             pingpong_o
);
  localparam int UB = ENV_W - DW;

  logic wr_car_ctl, wr_env_ctl;
  assign wr_car_ctl = wr_en_i && (addr_i == A_CAR_CTL);
  assign wr_env_ctl = wr_en_i && (addr_i == A_ENV_CTL);
  assign pingpong_o = (env_sub_o == SUB_PINGPONG) && car_single_o && env_single_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      car_hi_o <= '0;
      car_lo_o <= '0;
      env_hi_o <= '0;
      env_lo_o <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_CAR_HI:   car_hi_o <= wdata_i[CAR_W-1:0];
        A_CAR_LO:   car_lo_o <= wdata_i[CAR_W-1:0];
        A_ENV_HI_H: env_hi_o[ENV_W-1:UB] <= wdata_i;
        A_ENV_HI_L: env_hi_o[DW-1:0]     <= wdata_i;
        A_ENV_LO_H: env_lo_o[ENV_W-1:UB] <= wdata_i;
        A_ENV_LO_L: env_lo_o[DW-1:0]     <= wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      car_en_o     <= 1'b0;
      car_single_o <= 1'b0;
      car_mask_o   <= 1'b0;
      car_init_o   <= 1'b0;
    end else if (wr_car_ctl) begin
      car_en_o     <= wdata_i[B_EN];
      car_single_o <= wdata_i[B_SINGLE];
      car_mask_o   <= wdata_i[B_MASK];
      car_init_o   <= wdata_i[B_INIT];
    end else if (car_done_i) begin
      car_en_o <= 1'b0;
    end else if (env_done_i && pingpong_o) begin
      car_en_o <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      env_en_o     <= 1'b0;
      env_single_o <= 1'b0;
      env_sync_o   <= 1'b0;
      env_sub_o    <= SUB_NORMAL;
      env_mask_o   <= 1'b0;
      env_init_o   <= 1'b0;
    end else if (wr_env_ctl) begin
      env_en_o     <= wdata_i[B_EN];
      env_single_o <= wdata_i[B_SINGLE];
      env_sync_o   <= wdata_i[B_SYNC];
      env_sub_o    <= sub_e'(wdata_i[3:2]);
      env_mask_o   <= wdata_i[B_MASK];
      env_init_o   <= wdata_i[B_INIT];
    end else if (env_done_i) begin
      env_en_o <= 1'b0;
    end else if (car_done_i && pingpong_o) begin
      env_en_o <= 1'b1;
    end
  end

  // status: hardware set wins over a clearing write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      car_sts_o <= 1'b0;
      env_sts_o <= 1'b0;
    end else begin
      if (car_period_i)                        car_sts_o <= 1'b1;
      else if (wr_car_ctl && wdata_i[B_STS])   car_sts_o <= 1'b0;
      if (env_period_i)                        env_sts_o <= 1'b1;
      else if (wr_env_ctl && wdata_i[B_STS])   env_sts_o <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CAR_HI:   rdata_o = DW'(car_hi_o);
      A_CAR_LO:   rdata_o = DW'(car_lo_o);
      A_ENV_HI_H: rdata_o = env_hi_o[ENV_W-1:UB];
      A_ENV_HI_L: rdata_o = env_hi_o[DW-1:0];
      A_ENV_LO_H: rdata_o = env_lo_o[ENV_W-1:UB];
      A_ENV_LO_L: rdata_o = env_lo_o[DW-1:0];
      A_CAR_CTL:  rdata_o = DW'({car_en_o, car_single_o, car_sts_o, 3'b000,
                                 car_mask_o, car_init_o});
      A_ENV_CTL:  rdata_o = DW'({env_en_o, env_single_o, env_sts_o, env_sync_o,
                                 env_sub_o, env_mask_o, env_init_o});
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irtp_outmux.sv
module irtp_outmux import irtp_pkg::*; (
  input  logic car_run_i,
  input  logic car_level_i,
  input  logic env_run_i,
  input  logic env_level_i,
  input  logic env_init_i,
  input  sub_e env_sub_i,
  output logic carrier_o,
  output logic envelope_o,
  output logic mod_o
);
  logic env_live;

  assign carrier_o = car_run_i & car_level_i;
  assign env_live  = env_run_i ? env_level_i : ~env_init_i;

  always_comb begin
    case (env_sub_i)
      SUB_FORCE0: envelope_o = 1'b0;
      SUB_FORCE1: envelope_o = 1'b1;
      default:    envelope_o = env_live;
    endcase
    mod_o = (env_sub_i == SUB_PINGPONG) ? (carrier_o | envelope_o)
                                        : (carrier_o & envelope_o);
  end
endmodule

// File: rtl/ir_timer_pair.sv
module ir_timer_pair import irtp_pkg::*; #(
  parameter int CAR_W = 8,
  parameter int ENV_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              carrier_o,
  output logic              envelope_o,
  output logic              mod_o,
  output logic              irq_car_o,
  output logic              irq_env_o
);
  logic [CAR_W-1:0] car_hi, car_lo;
  logic [ENV_W-1:0] env_hi, env_lo;
  logic car_en, car_single, car_sts, car_mask, car_init;
  logic env_en, env_single, env_sts, env_sync, env_mask, env_init;
  sub_e env_sub_e;
  logic [1:0] env_sub;
  logic pingpong;
  logic car_run, car_level, car_period, car_done, car_restart;
  logic env_run, env_level, env_period, env_done;

  assign env_sub = env_sub_e;

  irtp_regs #(.CAR_W(CAR_W), .ENV_W(ENV_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .car_period_i(car_period), .car_done_i(car_done),
    .env_period_i(env_period), .env_done_i(env_done),
    .car_hi_o(car_hi), .car_lo_o(car_lo), .env_hi_o(env_hi), .env_lo_o(env_lo),
    .car_en_o(car_en), .car_single_o(car_single), .car_sts_o(car_sts),
    .car_mask_o(car_mask), .car_init_o(car_init),
    .env_en_o(env_en), .env_single_o(env_single), .env_sts_o(env_sts),
    .env_sync_o(env_sync), .env_sub_o(env_sub_e), .env_mask_o(env_mask),
    .env_init_o(env_init), .pingpong_o(pingpong)
  );

  // sync: carrier held at its start point while the envelope is low
  assign car_restart = env_sync && (env_sub_e == SUB_NORMAL) && !envelope_o;

  irtp_counter #(.W(CAR_W)) u_car (
    .clk_i, .rst_ni, .en_i(car_en), .single_i(car_single), .init_i(car_init),
    .restart_i(car_restart), .hold_hi_i(car_hi), .hold_lo_i(car_lo),
    .run_o(car_run), .level_o(car_level), .period_o(car_period), .done_o(car_done)
  );

  irtp_counter #(.W(ENV_W)) u_env (
    .clk_i, .rst_ni, .en_i(env_en), .single_i(env_single), .init_i(env_init),
    .restart_i(1'b0), .hold_hi_i(env_hi), .hold_lo_i(env_lo),
    .run_o(env_run), .level_o(env_level), .period_o(env_period), .done_o(env_done)
  );

  irtp_outmux u_out (
    .car_run_i(car_run), .car_level_i(car_level),
    .env_run_i(env_run), .env_level_i(env_level), .env_init_i(env_init),
    .env_sub_i(env_sub_e),
    .carrier_o, .envelope_o, .mod_o
  );

  assign irq_car_o = car_sts & car_mask;
  assign irq_env_o = env_sts & env_mask;
endmodule

// File: rtl/irtp_checker.sv
module irtp_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic       carrier_o,
  input logic       envelope_o,
  input logic       irq_car_o,
  input logic       irq_env_o,
  input logic       car_en,
  input logic       env_en,
  input logic       car_run,
  input logic       env_run,
  input logic       car_sts,
  input logic       env_sts,
  input logic       car_period,
  input logic       env_period,
  input logic       car_done,
  input logic       env_done,
  input logic       car_restart,
  input logic       car_init,
  input logic [1:0] env_sub,
  input logic       pingpong
);
  assert_car_run_en_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    car_run |-> $past(car_en));
  assert_env_run_en_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    env_run |-> $past(env_en));

  assert_car_single_end_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (car_done && !wr_en_i) |=> (car_sts && !car_en && !car_run));
  assert_env_single_end_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (env_done && !wr_en_i) |=> (env_sts && !env_en && !env_run));

  assert_car_sts_source_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(car_sts) |-> $past(car_period));
  assert_env_sts_source_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(env_sts) |-> $past(env_period));

  assert_car_irq_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_car_o) |-> ($past(car_period) || $past(wr_en_i)));
  assert_env_irq_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_env_o) |-> ($past(env_period) || $past(wr_en_i)));

  assert_pp_handoff_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (car_done && pingpong && !wr_en_i && !env_done) |=> env_en);

  assert_forced_steady_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (env_sub[1] && $stable(env_sub)) |-> $stable(envelope_o));

  assert_sync_restart_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (car_restart && car_en && !wr_en_i) |=> (carrier_o == $past(car_init)));
endmodule

bind ir_timer_pair irtp_checker u_chk (.*);

// File: tb/ir_timer_pair_test.sv
module ir_timer_pair_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       carrier, envelope, modo, irq_car, irq_env;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ir_timer_pair uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .carrier_o(carrier), .envelope_o(envelope), .mod_o(modo),
    .irq_car_o(irq_car), .irq_env_o(irq_env)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic set_car(input logic [7:0] hi, input logic [7:0] lo);
    wr(3'd0, hi); wr(3'd1, lo);
  endtask

  task automatic set_env(input logic [15:0] hi, input logic [15:0] lo);
    wr(3'd2, hi[15:8]); wr(3'd3, hi[7:0]); wr(3'd4, lo[15:8]); wr(3'd5, lo[7:0]);
  endtask

  // expected output k cycles into a run: level 1 lasts lo+1, level 0 lasts hi+1
  function automatic logic wave(int k, logic init, int hi, int lo);
    int m;
    m = k % (hi + lo + 2);
    if (init) return (m < lo + 1);
    return !(m < hi + 1);
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 carrier", carrier, 0);
    chk("R1 envelope", envelope, 1);
    chk("R1 mod", modo, 0);
    chk("R1 irq_car", irq_car, 0);
    chk("R1 irq_env", irq_env, 0);
    rd(3'd6, d); chk("R1 car ctl", d, 0);
    rd(3'd7, d); chk("R1 env ctl", d, 0);
  endtask

  task automatic t_car_modulo();
    logic [7:0] d;
    set_car(8'd2, 8'd1);
    wr(3'd6, 8'h80);
    step();
    for (int k = 0; k < 12; k++) begin
      chk("R2 R3 carrier modulo", carrier, wave(k, 1'b0, 2, 1));
      step();
    end
    rd(3'd6, d);
    chk("R3 status after periods", d[5], 1);
    chk("R3 still enabled", d[7], 1);
    wr(3'd6, 8'h20);
    step();
    for (int k = 0; k < 4; k++) begin
      chk("R13 carrier stopped", carrier, 0);
      step();
    end
    rd(3'd6, d);
    chk("R5 status cleared", d[5], 0);
  endtask

  task automatic t_car_single();
    logic [7:0] d;
    set_car(8'd3, 8'd2);
    wr(3'd6, 8'hC1);
    step();
    for (int k = 0; k < 7; k++) begin
      chk("R2 R4 carrier single", carrier, wave(k, 1'b1, 3, 2));
      step();
    end
    chk("R4 carrier idle after run", carrier, 0);
    chk("R5 masked irq", irq_car, 0);
    rd(3'd6, d);
    chk("R4 enable cleared", d[7], 0);
    chk("R4 status set", d[5], 1);
    wr(3'd6, 8'h00);
    rd(3'd6, d);
    chk("R5 zero write keeps status", d[5], 1);
    wr(3'd6, 8'h02);
    chk("R5 irq when unmasked", irq_car, 1);
    wr(3'd6, 8'h22);
    rd(3'd6, d);
    chk("R5 status cleared", d[5], 0);
    chk("R5 irq dropped", irq_car, 0);
    wr(3'd6, 8'h00);
  endtask

  task automatic t_env_idle_force();
    chk("R6 idle init0", envelope, 1);
    wr(3'd7, 8'h01);
    chk("R6 idle init1", envelope, 0);
    wr(3'd7, 8'h08);
    chk("R7 force 0", envelope, 0);
    wr(3'd7, 8'h0D);
    chk("R7 force 1", envelope, 1);
    set_env(16'd2, 16'd2);
    wr(3'd7, 8'h88);
    for (int k = 0; k < 6; k++) begin
      step();
      chk("R7 force 0 running", envelope, 0);
    end
    wr(3'd7, 8'h8C);
    for (int k = 0; k < 6; k++) begin
      step();
      chk("R7 force 1 running", envelope, 1);
    end
    wr(3'd7, 8'h20);
    step();
    chk("R6 idle after stop", envelope, 1);
  endtask

  task automatic t_env_mod_and();
    logic e, c;
    set_car(8'd1, 8'd1);
    set_env(16'h0102, 16'h0003);
    wr(3'd6, 8'h80);
    wr(3'd7, 8'h81);
    step();
    for (int k = 0; k < 600; k++) begin
      e = wave(k, 1'b1, 258, 3);
      c = wave(k + 1, 1'b0, 1, 1);
      chk("R2 R12 envelope 16-bit", envelope, e);
      chk("R3 carrier modulo", carrier, c);
      chk("R8 mod AND", modo, c & e);
      step();
    end
    wr(3'd7, 8'h20);
    wr(3'd6, 8'h20);
    step();
    wr(3'd6, 8'h20);
    wr(3'd7, 8'h20);
  endtask

  task automatic t_hold_rewrite();
    logic x;
    int m;
    set_car(8'd4, 8'd4);
    wr(3'd6, 8'h80);
    step();
    for (int k = 0; k < 21; k++) begin
      if (k < 5) x = 1'b0;
      else if (k < 10) x = 1'b1;
      else begin
        m = (k - 10) % 7;
        x = (m >= 2);
      end
      chk("R12 hold rewrite", carrier, x);
      if (k == 1) wr(3'd0, 8'd1);
      else step();
    end
    wr(3'd6, 8'h20);
    step();
    wr(3'd6, 8'h20);
  endtask

  task automatic t_pingpong();
    logic [16:0] car_pp, env_pp;
    logic [7:0] d;
    car_pp = 17'((1 << 3) | (1 << 4) | (1 << 15) | (1 << 16));
    env_pp = 17'((1 << 6) | (1 << 7) | (1 << 8));
    set_car(8'd1, 8'd1);
    set_env(16'd2, 16'd2);
    wr(3'd7, 8'h45);
    wr(3'd6, 8'hC0);
    for (int s = 1; s <= 16; s++) begin
      step();
      chk("R9 pingpong carrier", carrier, car_pp[s]);
      chk("R9 pingpong envelope", envelope, env_pp[s]);
      chk("R10 mod OR", modo, car_pp[s] | env_pp[s]);
      if (s == 12) begin
        rd(3'd6, d); chk("R9 carrier re-enabled", d[7], 1);
        rd(3'd7, d); chk("R9 envelope status", d[5], 1);
      end
    end
    wr(3'd7, 8'h20);
    wr(3'd6, 8'h20);
    step();
    rd(3'd7, d);
    chk("R9 chain stopped", d[7], 0);
    wr(3'd6, 8'h20);
  endtask

  task automatic t_sync();
    int hc;
    set_car(8'd0, 8'd0);
    set_env(16'd5, 16'd3);
    wr(3'd7, 8'h90);
    wr(3'd6, 8'h81);
    hc = 0;
    for (int k = 0; k < 40; k++) begin
      step();
      if (envelope) begin
        hc++;
        chk("R11 sync carrier", carrier, hc % 2);
        chk("R11 sync mod", modo, hc % 2);
      end else begin
        if (hc != 0) chk("R11 burst length", hc, 4);
        hc = 0;
        chk("R8 mod low outside burst", modo, 0);
      end
    end
    wr(3'd6, 8'h20);
    wr(3'd7, 8'h20);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_car_modulo();
    t_car_single();
    t_env_idle_force();
    t_env_mod_and();
    t_hold_rewrite();
    t_pingpong();
    t_sync();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule